// File: doc/BRIEF.md
# DMA Bus Tenure Governor

This block keeps a DMA engine fair to the other masters on a shared backplane bus. Once the DMA is granted the bus, a tenure cap limits how long it may keep it. Once it lets go, a rest gap holds back further requests for a minimum time. Both limits are picked by 3-bit codes, which are converted into clock cycles through a cycles-per-microsecond parameter.

The arbiter and the data mover sit outside. The governor watches the DMA's wish for the bus, the grant and the end-of-transfer flag. It answers with a permission level that gates the DMA's bus request, and with a one-cycle pulse that tells the DMA to give the bus up because its cap has run out. Each code is captured when its phase begins, so changing a code never stretches or shortens a phase that is already running.

Top module: `dma_tenure_governor`

## Requirements
- R1: After reset the governor is idle: `req_ok` is 1 and `must_release` is 0.
- R2: The governor leaves idle only at a clock edge where `dma_want` and `bus_grant` are both 1. `req_ok` is 0 from the next cycle for as long as the tenure lasts. Either input alone leaves it idle.
- R3: For `cap_code` values 0 to 6, the tenure lasts at most (16 << `cap_code`) µs, which is that many microseconds times `CLKS_PER_US` cycles. With the grant held and `xfer_done` low, the tenure lasts exactly that number of cycles. `must_release` is 1 in its last cycle only.
- R4: With `cap_code` = 7 the tenure has no cap. It lasts until `xfer_done` or the loss of the grant, and `must_release` never asserts.
- R5: During a tenure, `xfer_done` = 1 or `bus_grant` = 0 ends the tenure at that clock edge without `must_release`. This also holds in the very cycle in which the cap expires.
- R6: For `gap_code` values 1 to 7, after a tenure ends `req_ok` stays 0 for exactly (16 << (`gap_code`-1)) µs × `CLKS_PER_US` cycles and then returns to 1.
- R7: With `gap_code` = 0 there is no rest gap: `req_ok` is 1 in the cycle right after the last cycle of the tenure.
- R8: `cap_code` is captured when a tenure starts and `gap_code` when it ends. Changes made to either code during a phase do not change the length of that phase.
- R9: During the rest gap, `dma_want`, `bus_grant` and `xfer_done` are ignored: `req_ok` stays 0 for the full gap whatever they do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_code | input | 3 | Tenure cap select (0..6 capped, 7 = until done) |
| gap_code | input | 3 | Rest gap select (0 = none, 1..7 capped) |
| dma_want | input | 1 | DMA wishes to own the bus |
| bus_grant | input | 1 | Arbiter has granted the bus to the DMA |
| xfer_done | input | 1 | Transfer finished or no data left |
| req_ok | output | 1 | DMA may request the bus |
| must_release | output | 1 | One-cycle pulse: cap expired, release the bus |

## Verification
The cap can expire in the same cycle in which the transfer ends, either through `xfer_done` or through loss of the grant. The bench provokes this by holding the grant with a 16 µs cap and raising `xfer_done` in exactly the last cycle of the tenure, and separately by dropping the grant in that cycle. It judges the result on both outputs: `must_release` must stay 0 and the rest gap must start on the same edge as an expiry would start it. A behavioural model compares both outputs on every cycle, including long runs under the uncapped code and code changes made during a phase.

// File: rtl/tenure_pkg.sv
package tenure_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ON   = 2'd1,
      PH_OFF  = 2'd2
   } phase_t;

   // microseconds selected by a cap code; code 7 yields 0 (no cap)
   function automatic int unsigned cap_us(input int unsigned code, input int unsigned base_us);
      if (code >= 7) return 0;
      return base_us << code;
   endfunction

   // microseconds selected by a gap code; code 0 yields 0 (no gap)
   function automatic int unsigned gap_us(input int unsigned code, input int unsigned base_us);
      if (code == 0) return 0;
      return base_us << (code - 1);
   endfunction

endpackage

// File: rtl/tenure_limit_decode.sv
module tenure_limit_decode
   import tenure_pkg::*;
#(
   parameter int unsigned CODE_W      = 3,
   parameter int unsigned BASE_US     = 16,
   parameter int unsigned CLKS_PER_US = 200,
   parameter int unsigned CNT_W       = 18,
   parameter bit          GAP_TABLE   = 1'b0
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  limit_cycles,
   output logic              unlimited
);

   localparam int unsigned LAST_CODE = (1 << CODE_W) - 1;

   initial begin
      assert (CODE_W == 3) else $fatal(1, "tenure_limit_decode: CODE_W must be 3");
      assert (BASE_US >= 1) else $fatal(1, "tenure_limit_decode: BASE_US must be positive");
   end

   generate
      if (GAP_TABLE) begin : g_gap
         always_comb begin
            limit_cycles = CNT_W'(gap_us(int'(code), BASE_US) * CLKS_PER_US);
            unlimited    = 1'b0;
         end
      end else begin : g_cap
         always_comb begin
            limit_cycles = CNT_W'(cap_us(int'(code), BASE_US) * CLKS_PER_US);
            unlimited    = (int'(code) == LAST_CODE);
         end
      end
   endgenerate

endmodule

// File: rtl/tenure_timer.sv
module tenure_timer #(
   parameter int unsigned CNT_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   initial assert (CNT_W >= 2) else $fatal(1, "tenure_timer: CNT_W too small");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (load)        cnt_q <= load_val;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // a_r3_timer_counts_down: a nonzero count without load decreases by one
   a_r3_timer_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> ($past(cnt_q) - 1'b1 == cnt_q));

endmodule

// File: rtl/dma_tenure_governor.sv
module dma_tenure_governor
   import tenure_pkg::*;
#(
   parameter int unsigned CLKS_PER_US = 200,
   parameter int unsigned BASE_US     = 16,
   parameter int unsigned CODE_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] cap_code,
   input  logic [CODE_W-1:0] gap_code,
   input  logic              dma_want,
   input  logic              bus_grant,
   input  logic              xfer_done,
   output logic              req_ok,
   output logic              must_release
);

   localparam int unsigned MAX_US  = BASE_US << ((1 << CODE_W) - 2);
   localparam int unsigned MAX_CYC = MAX_US * CLKS_PER_US;
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   initial begin
      assert (CLKS_PER_US >= 1) else $fatal(1, "dma_tenure_governor: CLKS_PER_US must be positive");
      assert (CODE_W == 3) else $fatal(1, "dma_tenure_governor: CODE_W must be 3");
   end

   phase_t           phase_q;
   logic             hold_q;
   logic [CNT_W-1:0] cap_cyc, gap_cyc, load_val;
   logic             cap_open, gap_unused;
   logic             timer_load, timer_zero;
   logic             start_on, end_on, cap_hit;

   tenure_limit_decode #(
      .CODE_W(CODE_W), .BASE_US(BASE_US), .CLKS_PER_US(CLKS_PER_US),
      .CNT_W(CNT_W), .GAP_TABLE(1'b0)
   ) u_cap_dec (
      .code(cap_code), .limit_cycles(cap_cyc), .unlimited(cap_open)
   );

   tenure_limit_decode #(
      .CODE_W(CODE_W), .BASE_US(BASE_US), .CLKS_PER_US(CLKS_PER_US),
      .CNT_W(CNT_W), .GAP_TABLE(1'b1)
   ) u_gap_dec (
      .code(gap_code), .limit_cycles(gap_cyc), .unlimited(gap_unused)
   );

   tenure_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(load_val),
      .expired(timer_zero)
   );

   always_comb begin
      start_on   = (phase_q == PH_IDLE) && dma_want && bus_grant;
      cap_hit    = (phase_q == PH_ON) && !hold_q && timer_zero && bus_grant && !xfer_done;
      end_on     = (phase_q == PH_ON) && (!bus_grant || xfer_done || cap_hit);
      timer_load = start_on || end_on;
      if (start_on) load_val = (cap_open || cap_cyc == '0) ? '0 : cap_cyc - 1'b1;
      else          load_val = (gap_cyc == '0) ? '0 : gap_cyc - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         hold_q  <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (start_on) begin
               phase_q <= PH_ON;
               hold_q  <= cap_open;
            end
            PH_ON: if (end_on) begin
               phase_q <= (gap_cyc == '0) ? PH_IDLE : PH_OFF;
            end
            PH_OFF: if (timer_zero) phase_q <= PH_IDLE;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign req_ok       = (phase_q == PH_IDLE);
   assign must_release = cap_hit;

   // R2 entry only on want and grant together
   a_r2_enter_on_request: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ok && dma_want && bus_grant) |=> !req_ok);
   a_r2_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ok && !(dma_want && bus_grant)) |=> req_ok);
   // R3 release pulse is single and closes the tenure
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      must_release |=> !must_release);
   a_r3_pulse_ends_tenure: assert property (@(posedge clk) disable iff (!rst_n)
      must_release |=> (phase_q != PH_ON));
   // R4 uncapped tenure never gets a release pulse
   a_r4_no_pulse_when_open: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_ON && hold_q) |-> !must_release);
   // R5 finishing transfer suppresses the pulse
   a_r5_done_beats_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done || !bus_grant) |-> !must_release);
   // R9 the rest gap blocks requests until its timer runs out
   a_r9_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_OFF && !timer_zero) |=> (phase_q == PH_OFF && !req_ok));

endmodule

// File: tb/sim_dma_tenure_governor.sv
module sim_dma_tenure_governor;

   localparam int CPU = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cap_code = 3'd0, gap_code = 3'd0;
   logic       dma_want = 1'b0, bus_grant = 1'b0, xfer_done = 1'b0;
   logic       req_ok, must_release;

   int    vectors = 0, misses = 0, cycles = 0;
   string cur_req = "R1";

   // behavioural model state
   int m_st = 0, m_el = 0, m_cap = 0, m_gap = 0;
   bit m_open = 0;

   always #2.5 clk = ~clk;

   dma_tenure_governor #(.CLKS_PER_US(CPU)) u0 (
      .clk(clk), .rst_n(rst_n), .cap_code(cap_code), .gap_code(gap_code),
      .dma_want(dma_want), .bus_grant(bus_grant), .xfer_done(xfer_done),
      .req_ok(req_ok), .must_release(must_release)
   );

   function automatic int cap_len(input int c);
      return (c == 7) ? 0 : 16 * (2 ** c) * CPU;
   endfunction
   function automatic int gap_len(input int c);
      return (c == 0) ? 0 : 16 * (2 ** (c - 1)) * CPU;
   endfunction

   function automatic bit exp_rel();
      return (m_st == 1) && !m_open && bus_grant && !xfer_done && (m_el == m_cap - 1);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_el = 0; m_open = 0;
      end else begin
         if (m_st == 0) begin
            if (dma_want && bus_grant) begin
               m_st = 1; m_el = 0; m_open = (cap_code == 3'd7); m_cap = cap_len(int'(cap_code));
            end
         end else if (m_st == 1) begin
            if (!bus_grant || xfer_done || exp_rel()) begin
               m_gap = gap_len(int'(gap_code));
               m_el = 0;
               m_st = (m_gap == 0) ? 0 : 2;
            end else m_el++;
         end else begin
            if (m_el == m_gap - 1) m_st = 0;
            else m_el++;
         end
      end
   end

   task automatic step(input bit w, input bit g, input bit d);
      bit e_ok, e_rel;
      @(negedge clk);
      dma_want = w; bus_grant = g; xfer_done = d;
      #1;
      e_ok  = (m_st == 0);
      e_rel = exp_rel();
      vectors++;
      if (req_ok !== e_ok || must_release !== e_rel) begin
         misses++;
         $display("FAIL %s cycle %0d: req_ok=%b exp %b, must_release=%b exp %b",
                  cur_req, cycles, req_ok, e_ok, must_release, e_rel);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         misses++;
         $display("FAIL watchdog: cycles=%0d exp below 150000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      cur_req = "R1";
      repeat (3) step(0, 0, 0);

      cur_req = "R2";
      repeat (4) step(1, 0, 0);
      repeat (4) step(0, 1, 0);
      step(1, 1, 0);
      repeat (4) step(0, 1, 0);
      step(0, 1, 1);
      repeat (3) step(0, 0, 0);

      cur_req = "R3";
      gap_code = 3'd0;
      for (int c = 0; c < 7; c++) begin
         cap_code = 3'(c);
         repeat (cap_len(c) + 3) step(1, 1, 0);
         repeat (3) step(0, 0, 0);
      end

      cur_req = "R7";
      cap_code = 3'd0; gap_code = 3'd0;
      repeat (5) step(1, 1, 0);
      step(1, 1, 1);
      repeat (3) step(1, 1, 0);
      step(0, 0, 1);
      repeat (2) step(0, 0, 0);

      cur_req = "R6";
      for (int c = 1; c < 8; c++) begin
         gap_code = 3'(c);
         repeat (3) step(1, 1, 0);
         step(1, 1, 1);
         cur_req = "R9";
         for (int i = 0; i < gap_len(c) + 3; i++) step(i % 2 == 0, i % 3 != 0, i % 5 == 0);
         cur_req = "R6";
         repeat (2) step(0, 0, 0);
      end

      cur_req = "R4";
      cap_code = 3'd7; gap_code = 3'd1;
      repeat (2500) step(1, 1, 0);
      step(1, 0, 0);
      repeat (40) step(0, 0, 0);

      cur_req = "R5";
      cap_code = 3'd0; gap_code = 3'd1;
      repeat (cap_len(0)) step(1, 1, 0);
      step(1, 1, 1);
      repeat (gap_len(1) + 2) step(0, 0, 0);
      repeat (cap_len(0)) step(1, 1, 0);
      step(1, 0, 0);
      repeat (gap_len(1) + 2) step(0, 0, 0);

      cur_req = "R8";
      cap_code = 3'd0; gap_code = 3'd1;
      step(1, 1, 0);
      cap_code = 3'd6;
      repeat (cap_len(0) + 1) step(0, 1, 0);
      gap_code = 3'd7;
      repeat (gap_len(1) + 4) step(0, 0, 0);
      cap_code = 3'd1; gap_code = 3'd2;
      step(1, 1, 0);
      repeat (3) step(0, 1, 0);
      step(0, 1, 1);
      gap_code = 3'd0;
      repeat (gap_len(2) + 4) step(0, 0, 0);

      finish_run();
   end

endmodule